// File: doc/BRIEF.md
# Six-State Self-Correcting Counter

This block is a 3-bit synchronous counter that cycles through six of its eight codes in a fixed order: 000, 001, 010, 100, 101, 110, then 000 again. Each bit is modelled as a JK flip-flop. Its J and K inputs come from fixed excitation equations on the present state, and all three bits update on the same rising clock edge.

The codes 011 and 111 are not part of the cycle. The same excitation equations send each of them into the cycle on the next advancing edge, so the counter cannot stay stuck outside the loop. A combinational flag reports when the present code is one of these two gap codes.

A preset path loads any 3-bit code, gap codes included. This lets the surrounding logic, or a bench, place the counter in any state from the ports.

Top module: `skip6_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `count` becomes 000 after that edge and `off_cycle` is low.
- R2: With `rst` and `load` low and `en` high, each rising edge moves `count` to its successor in the order 000→001→010→100→101→110→000.
- R3: With `en` high, and `rst` and `load` low, a counter at the gap code 011 moves to 100 on the next edge.
- R4: With `en` high, and `rst` and `load` low, a counter at the gap code 111 moves to 000 on the next edge.
- R5: With `rst`, `load` and `en` all low, `count` keeps its value across a rising edge.
- R6: With `rst` low and `load` high, the next edge places `load_code` into `count` whatever the level of `en`. `load_code` bit 2 is the most significant bit, A.
- R7: `off_cycle` is high exactly when `count` is 011 or 111, in the same cycle.
- R8: `rst` takes priority over `load` and `en`. `load` takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to 000 |
| en | input | 1 | Advance enable |
| load | input | 1 | Preset strobe |
| load_code | input | 3 | Code placed into the counter on a preset |
| count | output | 3 | Present state, bit 2 = A, bit 0 = C |
| off_cycle | output | 1 | High while the state is a gap code |

## Verification
The normal sequence never reaches the gap codes 011 and 111, so their recovery is the hardest behaviour to observe. The bench reaches each gap code by presetting it through `load` and `load_code`. It checks the flag while the gap code is held, then advances one edge and checks that the counter lands on 100 or 000. The same preset walk covers every code, so the successor of all eight states is checked, not only the six in the loop.

// File: rtl/skip6_pkg.sv
package skip6_pkg;
  localparam int STATE_W = 3;
  localparam int A_BIT = 2;
  localparam int B_BIT = 1;
  localparam int C_BIT = 0;

  typedef logic [STATE_W-1:0] code_t;

  typedef struct packed {
    logic [STATE_W-1:0] j;
    logic [STATE_W-1:0] k;
  } jk_bus_t;

  // Excitation: JA = KA = B, JB = C, KB = 1, JC = ~B, KC = 1
  function automatic jk_bus_t excite(code_t q);
    jk_bus_t r;
    r.j[A_BIT] = q[B_BIT];
    r.k[A_BIT] = q[B_BIT];
    r.j[B_BIT] = q[C_BIT];
    r.k[B_BIT] = 1'b1;
    r.j[C_BIT] = ~q[B_BIT];
    r.k[C_BIT] = 1'b1;
    return r;
  endfunction

  // Characteristic equation of a JK flip-flop
  function automatic logic jk_step(logic j, logic k, logic q);
    return (j & ~q) | (~k & q);
  endfunction

  function automatic logic is_gap(code_t q);
    return (q == 3'b011) || (q == 3'b111);
  endfunction

  // Intended successor written as a table, used only by checks
  function automatic code_t succ_table(code_t q);
    case (q)
      3'b000:  return 3'b001;
      3'b001:  return 3'b010;
      3'b010:  return 3'b100;
      3'b100:  return 3'b101;
      3'b101:  return 3'b110;
      3'b110:  return 3'b000;
      3'b011:  return 3'b100;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/skip6_excite.sv
module skip6_excite
  import skip6_pkg::*;
(
  input  code_t   q,
  output jk_bus_t jk
);
  always_comb jk = excite(q);
endmodule

// File: rtl/skip6_jk_cell.sv
module skip6_jk_cell (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_bit,
  input  logic adv,
  input  logic j,
  input  logic k,
  output logic q
);
  import skip6_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (load) q <= load_bit;
    else if (adv)  q <= jk_step(j, k, q);
  end

  // R2: J=K=1 while advancing complements the bit
  p_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && j && k) |=> (q != $past(q)));

  // R2: J=0, K=1 while advancing clears the bit
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && !j && k) |=> !q);
endmodule

// File: rtl/skip6_flag.sv
module skip6_flag
  import skip6_pkg::*;
(
  input  code_t q,
  output logic  gap
);
  always_comb gap = is_gap(q);
endmodule

// File: rtl/skip6_counter.sv
module skip6_counter
  import skip6_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               load,
  input  logic [STATE_W-1:0] load_code,
  output logic [STATE_W-1:0] count,
  output logic               off_cycle
);
  jk_bus_t jk_w;
  logic    adv_w;

  assign adv_w = en & ~load;

  skip6_excite u_exc (.q(count), .jk(jk_w));

  for (genvar i = 0; i < STATE_W; i++) begin : g_bit
    skip6_jk_cell u_cell (
      .clk(clk), .rst(rst), .load(load), .load_bit(load_code[i]),
      .adv(adv_w), .j(jk_w.j[i]), .k(jk_w.k[i]), .q(count[i])
    );
  end

  skip6_flag u_flag (.q(count), .gap(off_cycle));

  p_reset_r1: assert property (@(posedge clk) rst |=> (count == '0));

  p_reset_wins_r8: assert property (@(posedge clk) (rst && load) |=> (count == '0));

  p_succ_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !load && !off_cycle) |=> (count == succ_table($past(count))));

  p_gap011_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !load && count == 3'b011) |=> (count == 3'b100));

  p_gap111_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !load && count == 3'b111) |=> (count == 3'b000));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(count));

  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_code)));

  p_flag_r7: assert property (@(posedge clk) disable iff (rst)
    off_cycle |-> (count[0] && count[1]));

  p_escape_r7: assert property (@(posedge clk) disable iff (rst)
    (off_cycle && en && !load) |=> !off_cycle);
endmodule

// File: tb/skip6_counter_test.sv
module skip6_counter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       load = 1'b0;
  logic [2:0] load_code = 3'b000;
  logic [2:0] count;
  logic       off_cycle;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skip6_counter uut (
    .clk(clk), .rst(rst), .en(en), .load(load),
    .load_code(load_code), .count(count), .off_cycle(off_cycle)
  );

  // {preset code, successor, gap flag}
  localparam logic [6:0] VEC [8] = '{
    {3'b000, 3'b001, 1'b0},
    {3'b001, 3'b010, 1'b0},
    {3'b010, 3'b100, 1'b0},
    {3'b011, 3'b100, 1'b1},
    {3'b100, 3'b101, 1'b0},
    {3'b101, 3'b110, 1'b0},
    {3'b110, 3'b000, 1'b0},
    {3'b111, 3'b000, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic preset(input logic [2:0] c);
    load = 1'b1; load_code = c;
    tick();
    load = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] exp_c;
    // R1: reset state
    tick(); tick();
    chk("R1 reset count", count, 3'b000);
    chk("R7 flag after reset", {2'b00, off_cycle}, 3'b000);
    rst = 1'b0;

    // Table walk: preset every code, then advance once
    for (int i = 0; i < 8; i++) begin
      en = 1'b1;
      preset(VEC[i][6:4]);
      chk("R6 preset value", count, VEC[i][6:4]);
      chk("R7 gap flag", {2'b00, off_cycle}, {2'b00, VEC[i][0]});
      tick();
      if (VEC[i][6:4] == 3'b011)      chk("R3 recover from 011", count, VEC[i][3:1]);
      else if (VEC[i][6:4] == 3'b111) chk("R4 recover from 111", count, VEC[i][3:1]);
      else                            chk("R2 successor", count, VEC[i][3:1]);
      chk("R7 flag low after step", {2'b00, off_cycle}, 3'b000);
    end

    // R2: full loop twice from 000
    rst = 1'b1; tick(); rst = 1'b0;
    exp_c = 3'b000;
    for (int s = 0; s < 12; s++) begin
      tick();
      case (exp_c)
        3'b000: exp_c = 3'b001;
        3'b001: exp_c = 3'b010;
        3'b010: exp_c = 3'b100;
        3'b100: exp_c = 3'b101;
        3'b101: exp_c = 3'b110;
        default: exp_c = 3'b000;
      endcase
      chk("R2 loop step", count, exp_c);
    end

    // R5: hold with enable low, including a gap code
    en = 1'b0;
    preset(3'b101);
    tick(); tick();
    chk("R5 hold 101", count, 3'b101);
    preset(3'b111);
    tick(); tick();
    chk("R5 hold gap 111", count, 3'b111);
    chk("R7 flag while held", {2'b00, off_cycle}, 3'b001);

    // R6: load overrides counting when enabled
    en = 1'b1;
    preset(3'b010);
    chk("R6 load over enable", count, 3'b010);
    load = 1'b1; load_code = 3'b110;
    tick(); tick();
    chk("R8 load holds over count", count, 3'b110);
    load = 1'b0;

    // R8: reset beats load
    rst = 1'b1; load = 1'b1; load_code = 3'b011;
    tick();
    chk("R8 reset over load", count, 3'b000);
    rst = 1'b0; load = 1'b0; en = 1'b0;
    tick();
    chk("R1 stays after reset", count, 3'b000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule